// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver

This block decides whether a pending interrupt should interrupt the processor. It holds a software request register and a 5-bit priority mask register, and it takes a vector of external request lines. It scans all of these sources in one shared priority space. A software request bit is given the level equal to its offset inside the software field plus one. An external line is given the level equal to the bit position it occupies in the summary word. The highest pending level wins.

A scan is armed by a return-from-handler strobe, and each scan consumes that arming. When the winning level is nonzero and strictly above the mask, the block latches a summary word of every pending source and the winning level. On the next cycle it drives a one-cycle trap request. The control is a three-state machine:
- `ST_IDLE`: no scan pending.
- `ST_ARMED`: a scan is evaluated in this cycle.
- `ST_TRAP`: the trap pulse is driven.

The transitions are:
- IDLE→ARMED on the return strobe.
- ARMED→TRAP when the scan qualifies.
- ARMED→ARMED when the scan does not qualify and the return strobe is high.
- ARMED→IDLE when the scan does not qualify and the return strobe is low.
- TRAP→ARMED when the return strobe is high.
- TRAP→IDLE otherwise.

Top module: `irq_level_resolver`

## Requirements
- R1: After reset, `trap_o` is 0. `summary_o`, `intid_o`, `ipl_o` and `swreq_o` are 0, and no scan is armed.
- R2: A mask write (`ipl_we_i`) stores only `wdata_i[4:0]` into `ipl_o`, one cycle later.
- R3: A software request write (`swreq_we_i`) stores `wdata_i & 32'h0007_FFF0` into `swreq_o` (bits 18..4 only), one cycle later.
- R4: Software request bit p (4 ≤ p ≤ 18) has level p−3. Bit 4 is level 1 and bit 18 is level 15. When several are pending, the highest bit wins.
- R5: External line j (0..3) has level 20+j. Any pending external line outranks every software request, and the highest pending line wins.
- R6: The captured summary has bit p set for each pending software bit p, and bit 20+j set for each pending external line j. All other bits are 0.
- R7: A scan traps only when the resolved level is nonzero and strictly greater than the mask value in that cycle. A level equal to the mask causes no trap and leaves `summary_o` and `intid_o` unchanged.
- R8: `trap_o` is high for exactly one cycle. It rises on the clock edge that ends the qualifying scan cycle, and `summary_o` and `intid_o` take their new values on that same edge. At all other times they hold their values.
- R9: A scan happens only in the cycle after a return strobe. Each scan disarms, so pending requests never trap without a fresh strobe.
- R10: A return strobe during a scan that does not trap keeps the block armed for the next cycle. During a scan that traps, the strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ipl_we_i | input | 1 | Mask register write enable |
| swreq_we_i | input | 1 | Software request register write enable |
| wdata_i | input | 32 | Write data for both registers |
| ext_req_i | input | 4 | External request lines |
| handler_ret_i | input | 1 | Return-from-handler strobe; arms a scan |
| ipl_o | output | 5 | Current priority mask |
| swreq_o | output | 32 | Software request register |
| summary_o | output | 32 | Latched pending-source summary |
| intid_o | output | 5 | Latched winning level |
| trap_o | output | 1 | One-cycle trap request |

## Verification
The hardest case to reach from the ports is a non-trapping scan that coincides with both a return strobe and a mask write on the same edge. The scan must use the old mask, and the block must stay armed so that the next cycle traps under the new mask. The stimulus builds this directly: it first raises the mask to 31, then holds the strobe for two cycles and writes a mask of 0 on the second edge. A reference model then follows a long random mix of strobes, mask writes and request changes, and it is compared with the outputs on every cycle.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_TRAP  = 2'd2
    } scan_state_e;

endpackage

// File: rtl/irq_req_regs.sv
module irq_req_regs #(
    parameter int DATA_W = 32,
    parameter int LVL_W  = 5,
    parameter int SW_LO  = 4,
    parameter int SW_NUM = 15
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ipl_we_i,
    input  logic              swreq_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [LVL_W-1:0]  ipl_q_o,
    output logic [DATA_W-1:0] swreq_q_o
);
    localparam logic [DATA_W-1:0] ONES    = '1;
    localparam logic [DATA_W-1:0] SW_MASK = (ONES >> (DATA_W - SW_NUM)) << SW_LO;

    logic [LVL_W-1:0]  ipl_q;
    logic [DATA_W-1:0] swreq_q;

    // Mask register: low LVL_W bits of the write data only.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ipl_q <= '0;
        end else if (ipl_we_i) begin
            ipl_q <= wdata_i[LVL_W-1:0];
        end
    end

    // Software request register: the request field only.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            swreq_q <= '0;
        end else if (swreq_we_i) begin
            swreq_q <= wdata_i & SW_MASK;
        end
    end

    assign ipl_q_o   = ipl_q;
    assign swreq_q_o = swreq_q;

    // R2: the mask register follows the written low field.
    p_ipl_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ipl_we_i |=> ipl_q_o == $past(wdata_i[LVL_W-1:0]));

    // R3: the software request register keeps only its field.
    p_swreq_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        swreq_we_i |=> swreq_q_o == ($past(wdata_i) & SW_MASK));

endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
    parameter int DATA_W  = 32,
    parameter int LVL_W   = 5,
    parameter int SW_LO   = 4,
    parameter int SW_NUM  = 15,
    parameter int EXT_LO  = 20,
    parameter int EXT_NUM = 4
) (
    input  logic [SW_NUM-1:0]  sw_field_i,
    input  logic [EXT_NUM-1:0] ext_req_i,
    output logic [LVL_W-1:0]   level_o,
    output logic [DATA_W-1:0]  summary_o
);
    // Software levels run 1..SW_NUM. External levels equal their bit
    // position, so they must sit above the software field and fit in LVL_W.
    initial begin
        if (EXT_LO <= SW_LO + SW_NUM - 1) $error("external field overlaps software field");
        if (EXT_LO + EXT_NUM > (1 << LVL_W)) $error("external level exceeds level width");
        if (EXT_LO + EXT_NUM > DATA_W) $error("external field exceeds data width");
    end

    logic [DATA_W-1:0] sw_sum;
    logic [DATA_W-1:0] ext_sum;

    // Summary placement: each source at its own request position.
    generate
        for (genvar gs = 0; gs < DATA_W; gs++) begin : g_sum_bit
            if (gs >= SW_LO && gs < SW_LO + SW_NUM) begin : g_sw
                assign sw_sum[gs]  = sw_field_i[gs - SW_LO];
                assign ext_sum[gs] = 1'b0;
            end else if (gs >= EXT_LO && gs < EXT_LO + EXT_NUM) begin : g_ext
                assign sw_sum[gs]  = 1'b0;
                assign ext_sum[gs] = ext_req_i[gs - EXT_LO];
            end else begin : g_none
                assign sw_sum[gs]  = 1'b0;
                assign ext_sum[gs] = 1'b0;
            end
        end
    endgenerate

    assign summary_o = sw_sum | ext_sum;

    // Software first, then external; a later hit overrides an earlier one.
    always_comb begin
        level_o = '0;
        for (int i = 0; i < SW_NUM; i++) begin
            if (sw_field_i[i]) level_o = LVL_W'(i + 1);
        end
        for (int j = 0; j < EXT_NUM; j++) begin
            if (ext_req_i[j]) level_o = LVL_W'(EXT_LO + j);
        end
    end

endmodule

// File: rtl/irq_trap_fsm.sv
module irq_trap_fsm
    import irq_lvl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LVL_W  = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ret_i,
    input  logic [LVL_W-1:0]  level_i,
    input  logic [DATA_W-1:0] summary_i,
    input  logic [LVL_W-1:0]  ipl_i,
    output logic              trap_o,
    output logic [DATA_W-1:0] sum_q_o,
    output logic [LVL_W-1:0]  intid_q_o
);
    scan_state_e state_q, state_d;
    logic        qualify;
    logic [DATA_W-1:0] sum_q;
    logic [LVL_W-1:0]  intid_q;

    assign qualify = (level_i != '0) && (level_i > ipl_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ret_i ? ST_ARMED : ST_IDLE;
            ST_ARMED: begin
                if (qualify)    state_d = ST_TRAP;
                else if (ret_i) state_d = ST_ARMED;
                else            state_d = ST_IDLE;
            end
            ST_TRAP:  state_d = ret_i ? ST_ARMED : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Capture registers: written on the edge that ends a qualifying scan.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sum_q   <= '0;
            intid_q <= '0;
        end else if (state_q == ST_ARMED && qualify) begin
            sum_q   <= summary_i;
            intid_q <= level_i;
        end
    end

    assign trap_o    = (state_q == ST_TRAP);
    assign sum_q_o   = sum_q;
    assign intid_q_o = intid_q;

    // R8: the trap request lasts one cycle.
    p_trap_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |=> !trap_o);

    // R8: captured values hold while no trap is being issued.
    p_capture_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !state_d[1] |=> $stable(sum_q_o) && $stable(intid_q_o));

    // R9: a trap always follows an armed scan cycle.
    p_trap_after_scan_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> $past(state_q == ST_ARMED));

    // R10: a non-trapping scan with a return strobe stays armed.
    p_rearm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ARMED && !qualify && ret_i) |=> state_q == ST_ARMED);

endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver #(
    parameter int DATA_W  = 32,
    parameter int LVL_W   = 5,
    parameter int SW_LO   = 4,
    parameter int SW_NUM  = 15,
    parameter int EXT_LO  = 20,
    parameter int EXT_NUM = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               ipl_we_i,
    input  logic               swreq_we_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [EXT_NUM-1:0] ext_req_i,
    input  logic               handler_ret_i,
    output logic [LVL_W-1:0]   ipl_o,
    output logic [DATA_W-1:0]  swreq_o,
    output logic [DATA_W-1:0]  summary_o,
    output logic [LVL_W-1:0]   intid_o,
    output logic               trap_o
);
    logic [LVL_W-1:0]  ipl_q;
    logic [DATA_W-1:0] swreq_q;
    logic [LVL_W-1:0]  scan_level;
    logic [DATA_W-1:0] scan_summary;

    irq_req_regs #(
        .DATA_W (DATA_W),
        .LVL_W  (LVL_W),
        .SW_LO  (SW_LO),
        .SW_NUM (SW_NUM)
    ) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ipl_we_i   (ipl_we_i),
        .swreq_we_i (swreq_we_i),
        .wdata_i    (wdata_i),
        .ipl_q_o    (ipl_q),
        .swreq_q_o  (swreq_q)
    );

    irq_prio_scan #(
        .DATA_W  (DATA_W),
        .LVL_W   (LVL_W),
        .SW_LO   (SW_LO),
        .SW_NUM  (SW_NUM),
        .EXT_LO  (EXT_LO),
        .EXT_NUM (EXT_NUM)
    ) u_scan (
        .sw_field_i (swreq_q[SW_LO +: SW_NUM]),
        .ext_req_i  (ext_req_i),
        .level_o    (scan_level),
        .summary_o  (scan_summary)
    );

    irq_trap_fsm #(
        .DATA_W (DATA_W),
        .LVL_W  (LVL_W)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ret_i     (handler_ret_i),
        .level_i   (scan_level),
        .summary_i (scan_summary),
        .ipl_i     (ipl_q),
        .trap_o    (trap_o),
        .sum_q_o   (summary_o),
        .intid_q_o (intid_o)
    );

    assign ipl_o   = ipl_q;
    assign swreq_o = swreq_q;

    // R7: a trap carries a level strictly above the mask used by its scan.
    p_above_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> (intid_o != '0) && (intid_o > $past(ipl_o)));

    // R6: a trap carries a nonzero summary.
    p_summary_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> summary_o != '0);

endmodule

// File: tb/test_irq_level_resolver.sv
`timescale 1ns/1ps
module test_irq_level_resolver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ipl_we = 1'b0;
    logic        swreq_we = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  ext_req = '0;
    logic        ret = 1'b0;
    logic [4:0]  ipl_o;
    logic [31:0] swreq_o;
    logic [31:0] summary_o;
    logic [4:0]  intid_o;
    logic        trap_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    irq_level_resolver i_irq_level_resolver (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .ipl_we_i      (ipl_we),
        .swreq_we_i    (swreq_we),
        .wdata_i       (wdata),
        .ext_req_i     (ext_req),
        .handler_ret_i (ret),
        .ipl_o         (ipl_o),
        .swreq_o       (swreq_o),
        .summary_o     (summary_o),
        .intid_o       (intid_o),
        .trap_o        (trap_o)
    );

    // Behavioural reference model.
    int          m_ipl, m_id;
    logic [31:0] m_sw, m_sum;
    bit          m_armed, m_trap;

    always @(posedge clk) begin
        int          lvl;
        logic [31:0] sum;
        bit          fire;
        if (!rst_n) begin
            m_ipl = 0; m_id = 0; m_sw = 0; m_sum = 0; m_armed = 0; m_trap = 0;
        end else begin
            lvl = 0; sum = 0;
            for (int p = 4; p <= 18; p++)
                if (m_sw[p]) begin lvl = p - 3; sum[p] = 1'b1; end
            for (int j = 0; j < 4; j++)
                if (ext_req[j]) begin lvl = 20 + j; sum[20 + j] = 1'b1; end
            fire = m_armed && (lvl != 0) && (lvl > m_ipl);
            if (fire) begin m_sum = sum; m_id = lvl; end
            m_trap  = fire;
            m_armed = ret && !fire;
            if (ipl_we)   m_ipl = int'(wdata[4:0]);
            if (swreq_we) m_sw  = wdata & 32'h0007_FFF0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison with the model, away from the rising edge.
    bit compare_on = 1'b0;
    always @(negedge clk) begin
        if (compare_on) begin
            chk("R8 trap vs model", {31'd0, trap_o}, {31'd0, m_trap});
            chk("R4 intid vs model", {27'd0, intid_o}, m_id[31:0]);
            chk("R6 summary vs model", summary_o, m_sum);
            chk("R2 ipl vs model", {27'd0, ipl_o}, m_ipl[31:0]);
            chk("R3 swreq vs model", swreq_o, m_sw);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr_ipl(input logic [31:0] v);
        @(negedge clk); ipl_we = 1'b1; wdata = v;
        @(negedge clk); ipl_we = 1'b0;
    endtask

    task automatic wr_sw(input logic [31:0] v);
        @(negedge clk); swreq_we = 1'b1; wdata = v;
        @(negedge clk); swreq_we = 1'b0;
    endtask

    // Return strobe; returns at the negedge after the scan edge.
    task automatic arm_and_scan();
        @(negedge clk); ret = 1'b1;
        @(negedge clk); ret = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 trap", {31'd0, trap_o}, 32'd0);
        chk("R1 summary", summary_o, 32'd0);
        chk("R1 intid", {27'd0, intid_o}, 32'd0);
        chk("R1 swreq", swreq_o, 32'd0);
        rst_n = 1'b1;
        compare_on = 1'b1;
        @(negedge clk);

        // R2: mask write keeps [4:0]
        wr_ipl(32'hFFFF_FFFF);
        chk("R2 ipl mask", {27'd0, ipl_o}, 32'd31);
        wr_ipl(32'h0000_0000);
        // R3: software write keeps [18:4]
        wr_sw(32'hFFFF_FFFF);
        chk("R3 swreq mask", swreq_o, 32'h0007_FFF0);
        // R9: pending requests without a strobe never trap
        repeat (4) begin
            @(negedge clk);
            chk("R9 no trap unarmed", {31'd0, trap_o}, 32'd0);
        end

        // R4: lowest software bit is level 1
        wr_sw(32'h0000_0010);
        arm_and_scan();
        chk("R8 trap pulse", {31'd0, trap_o}, 32'd1);
        chk("R4 level of bit 4", {27'd0, intid_o}, 32'd1);
        chk("R6 summary bit 4", summary_o, 32'h0000_0010);
        @(negedge clk);
        chk("R8 trap drops", {31'd0, trap_o}, 32'd0);

        // R4: highest software bit wins
        wr_sw(32'h0004_0020);
        arm_and_scan();
        chk("R4 level of bit 18", {27'd0, intid_o}, 32'd15);
        chk("R6 summary sw pair", summary_o, 32'h0004_0020);

        // R5/R6: external line outranks software
        ext_req = 4'b0101;
        arm_and_scan();
        chk("R5 ext level", {27'd0, intid_o}, 32'd22);
        chk("R6 summary mixed", summary_o, 32'h0054_0020);

        // R7: level equal to mask does not trap, captures hold
        wr_ipl(32'd22);
        arm_and_scan();
        chk("R7 equal no trap", {31'd0, trap_o}, 32'd0);
        chk("R7 summary held", summary_o, 32'h0054_0020);
        ext_req = 4'b1000;
        wr_ipl(32'd22);
        arm_and_scan();
        chk("R7 above mask traps", {31'd0, trap_o}, 32'd1);
        chk("R5 ext level 23", {27'd0, intid_o}, 32'd23);
        // R9: scan consumed; no second trap
        repeat (3) begin
            @(negedge clk);
            chk("R9 single scan", {31'd0, trap_o}, 32'd0);
        end

        // R10: strobe during a failing scan re-arms; same-edge mask write
        wr_ipl(32'd31);
        @(negedge clk); ret = 1'b1;
        @(negedge clk); ipl_we = 1'b1; wdata = 32'd0;
        @(negedge clk); ret = 1'b0; ipl_we = 1'b0;
        chk("R10 no trap at mask 31", {31'd0, trap_o}, 32'd0);
        @(negedge clk);
        chk("R10 rearmed trap", {31'd0, trap_o}, 32'd1);
        chk("R10 rearmed level", {27'd0, intid_o}, 32'd23);

        // Random phase, checked against the model every cycle.
        ext_req = '0;
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            ret      = ($urandom_range(0, 2) == 0);
            ipl_we   = ($urandom_range(0, 5) == 0);
            swreq_we = ($urandom_range(0, 4) == 0);
            wdata    = $urandom();
            if ($urandom_range(0, 3) == 0) wdata = wdata & 32'h0000_0F1F;
            if ($urandom_range(0, 3) == 0) ext_req = 4'($urandom());
            if ($urandom_range(0, 2) == 0) ext_req = '0;
        end
        @(negedge clk);
        ret = 1'b0; ipl_we = 1'b0; swreq_we = 1'b0;
        repeat (3) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule